// File: doc/BRIEF.md
# Bipolar Line Encoder with Violation Injection

This block sits at the end of a transmit path and turns a serial NRZ bit stream into two rail signals, one positive and one negative, for a line interface. In bipolar mode each 1 becomes a mark whose polarity alternates from the previous mark, and each 0 sends no pulse. In NRZ mode the data is passed to the positive rail and the negative rail stays low. Each pulse lasts either a full bit period or only its first half.

The block runs on a clock at twice the bit rate. A bit strobe marks the first half of each bit, and the data input is sampled on that strobe. A software request can inject one bipolar violation. The rising edge of the request arms a small state machine. Once the encoder has sent three consecutive ones after arming, the next mark is given the same polarity as the mark before it. A status output marks the bit that carried the violation.

The sequencer has three states. S_IDLE is unarmed. S_HUNT is armed and counting consecutive ones. S_READY is armed with the run complete. The transitions are ARM (S_IDLE to S_HUNT on a request edge), COUNT (a one inside S_HUNT), CLEAR (a zero inside S_HUNT resets the count), LOCK (the third one moves S_HUNT to S_READY) and FIRE (the next one in S_READY sends the violation and returns to S_IDLE).

Top module: `bipolar_line_encoder`

## Requirements
- R1: With `fmt_nrz`=0, every 1 produces a mark on exactly one rail, with the polarity alternating from the previous mark, and every 0 leaves both rails low. The rails are never high together.
- R2: With `fmt_nrz`=1, `pos_rail` follows the sampled data bit and `neg_rail` stays 0.
- R3: With `half_width`=0, the rails hold their value for both clock cycles of the bit. With `half_width`=1, the rails carry the pulse only in the first cycle after the strobe edge and are 0 in the second cycle.
- R4: A violation is armed only by a 0-to-1 change of `viol_req`. Holding the request high does not arm it again after a violation has been sent.
- R5: After arming, the violation waits for three consecutive ones. A 0 restarts the count, and the bit that arrives on the same strobe as the arming edge is not counted. Zeros that come after the third one do not cancel the violation.
- R6: The violating mark has the same polarity as the mark before it. The following marks alternate from the violating mark.
- R7: Each arming produces exactly one violation. A request pulse that falls before the violation is sent still produces it.
- R8: `viol_done` is 1 for exactly the bit period that carries the violating mark, and 0 at all other times.
- R9: A synchronous active-high `rst` drives both rails and `viol_done` low, cancels any armed request, clears the ones count, and sets the polarity so that the next mark is positive.
- R10: The outputs change only on the clock edge that samples a strobe, and on the following edge when `half_width`=1. The first half of a bit is the cycle right after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | High for one clock at the start of each bit; data is sampled here |
| nrz_in | input | 1 | Serial NRZ data |
| fmt_nrz | input | 1 | 0 = bipolar rails, 1 = NRZ on the positive rail |
| half_width | input | 1 | 0 = full-bit pulses, 1 = half-bit pulses |
| viol_req | input | 1 | Violation request; acts on its rising edge |
| pos_rail | output | 1 | Positive rail drive |
| neg_rail | output | 1 | Negative rail drive |
| viol_done | output | 1 | High for the bit period that carries the injected violation |

## Verification
A wrong polarity bit shows on the next mark as two marks of the same sign in a row, or as a violation that points the wrong way, within one bit period after the error. A wrong ones count or arming state moves the violation one or more marks earlier or later, or leaves it out. Either shows as a missing, early or late `viol_done` pulse, together with a rail pattern that differs from the expected polarity sequence within a few bits. Pulse shaping faults show inside a single bit as a second-half cycle that does not match the selected width.

// File: rtl/enc_pkg.sv
package enc_pkg;

    // Violation sequencer states
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HUNT  = 2'd1,
        S_READY = 2'd2
    } viol_state_t;

    // Rail pair carried between shaping stages
    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    localparam rail_t RAIL_OFF = '{pos: 1'b0, neg: 1'b0};

    // Build the rail pair for a bit given format, data and mark sign
    function automatic rail_t make_rail(input logic nrz_mode,
                                        input logic data,
                                        input logic negative);
        rail_t r;
        if (nrz_mode) begin
            r.pos = data;
            r.neg = 1'b0;
        end else begin
            r.pos = data & ~negative;
            r.neg = data &  negative;
        end
        return r;
    endfunction

endpackage

// File: rtl/req_edge.sv
module req_edge (
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    output logic rise_out
);

    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
        end else begin
            req_q <= req_in;
        end
    end

    assign rise_out = req_in & ~req_q;

endmodule

// File: rtl/viol_sequencer.sv
module viol_sequencer
    import enc_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_rise,
    input  logic        bit_stb,
    input  logic        data_bit,
    output logic        viol_now,
    output viol_state_t state_o
);

    localparam int CNT_W = (RUN_LEN < 2) ? 1 : $clog2(RUN_LEN);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RUN_LEN - 1);

    viol_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_rise) begin              // ARM
                    state_d = S_HUNT;
                    cnt_d   = '0;
                end
            end
            S_HUNT: begin
                if (bit_stb) begin
                    if (data_bit) begin
                        if (cnt_q == LAST_CNT) begin   // LOCK
                            state_d = S_READY;
                            cnt_d   = '0;
                        end else begin                 // COUNT
                            cnt_d = cnt_q + 1'b1;
                        end
                    end else begin                     // CLEAR
                        cnt_d = '0;
                    end
                end
            end
            S_READY: begin
                if (bit_stb && data_bit) begin         // FIRE
                    state_d = S_IDLE;
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        viol_now = (state_q == S_READY) && bit_stb && data_bit;
        state_o  = state_q;
    end

endmodule

// File: rtl/rail_shaper.sv
module rail_shaper
    import enc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic data_bit,
    input  logic viol_now,
    input  logic fmt_nrz,
    input  logic half_width,
    output logic pos_rail,
    output logic neg_rail,
    output logic viol_flag
);

    rail_t rail_q;
    logic  next_neg_q;   // sign of the next normal mark
    logic  flag_q;
    logic  mark_neg;
    rail_t rail_new;

    // A violation repeats the previous sign, which is the inverse of the next one
    always_comb begin
        mark_neg = viol_now ? ~next_neg_q : next_neg_q;
        rail_new = make_rail(fmt_nrz, data_bit, mark_neg);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rail_q     <= RAIL_OFF;
            next_neg_q <= 1'b0;
            flag_q     <= 1'b0;
        end else if (bit_stb) begin
            rail_q <= rail_new;
            flag_q <= viol_now;
            if (data_bit && !viol_now) begin
                next_neg_q <= ~next_neg_q;
            end
        end else if (half_width) begin
            rail_q <= RAIL_OFF;
        end
    end

    assign pos_rail  = rail_q.pos;
    assign neg_rail  = rail_q.neg;
    assign viol_flag = flag_q;

endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
    import enc_pkg::*;
#(
    parameter int RUN_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic nrz_in,
    input  logic fmt_nrz,
    input  logic half_width,
    input  logic viol_req,
    output logic pos_rail,
    output logic neg_rail,
    output logic viol_done
);

    logic        req_rise;
    logic        viol_now;
    viol_state_t seq_state;

    req_edge i_req_edge (
        .clk      (clk),
        .rst      (rst),
        .req_in   (viol_req),
        .rise_out (req_rise)
    );

    viol_sequencer #(
        .RUN_LEN (RUN_LEN)
    ) i_viol_sequencer (
        .clk      (clk),
        .rst      (rst),
        .req_rise (req_rise),
        .bit_stb  (bit_stb),
        .data_bit (nrz_in),
        .viol_now (viol_now),
        .state_o  (seq_state)
    );

    rail_shaper i_rail_shaper (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .data_bit   (nrz_in),
        .viol_now   (viol_now),
        .fmt_nrz    (fmt_nrz),
        .half_width (half_width),
        .pos_rail   (pos_rail),
        .neg_rail   (neg_rail),
        .viol_flag  (viol_done)
    );

endmodule

// File: rtl/bipolar_line_encoder_chk.sv
module bipolar_line_encoder_chk
    import enc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        bit_stb,
    input logic        fmt_nrz,
    input logic        half_width,
    input logic        pos_rail,
    input logic        neg_rail,
    input logic        viol_done,
    input viol_state_t seq_state
);

    // R1: the rails are never driven together
    p_rails_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(pos_rail && neg_rail));

    // R2: an NRZ-format bit leaves the negative rail low
    p_nrz_neg_low_r2: assert property (@(posedge clk) disable iff (rst)
        (bit_stb && fmt_nrz) |=> !neg_rail);

    // R3: in half-width mode the second half of a bit is idle
    p_half_second_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb && half_width) |=> (!pos_rail && !neg_rail));

    // R10: without a strobe in full-width mode the rails hold
    p_hold_between_strobes_r10: assert property (@(posedge clk) disable iff (rst)
        (!bit_stb && !half_width) |=> ($stable(pos_rail) && $stable(neg_rail)));

    // R5: a violation is sent only out of the ready state
    p_fire_from_ready_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_done) |-> ($past(seq_state) == S_READY));

    // R7: after firing the sequencer is disarmed
    p_one_shot_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_done) |-> (seq_state == S_IDLE));

    // R8: the violation flag starts together with a mark
    p_flag_on_mark_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(viol_done) |-> (pos_rail || neg_rail));

endmodule

bind bipolar_line_encoder bipolar_line_encoder_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_stb    (bit_stb),
    .fmt_nrz    (fmt_nrz),
    .half_width (half_width),
    .pos_rail   (pos_rail),
    .neg_rail   (neg_rail),
    .viol_done  (viol_done),
    .seq_state  (seq_state)
);

// File: tb/test_bipolar_line_encoder.sv
module test_bipolar_line_encoder;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;

    // {req, data, exp_pos, exp_neg, exp_viol}; bipolar, full width, from reset
    localparam logic [4:0] VEC [NVEC] = '{
        5'b0_1_100, 5'b0_0_000, 5'b0_1_010, 5'b1_1_100, 5'b1_1_010,
        5'b1_0_000, 5'b1_1_100, 5'b1_1_010, 5'b1_1_100, 5'b1_0_000,
        5'b1_1_101, 5'b1_1_010, 5'b1_1_100, 5'b1_1_010, 5'b1_1_100,
        5'b0_1_010, 5'b1_1_100, 5'b1_1_010, 5'b1_1_100, 5'b1_1_010,
        5'b1_1_011, 5'b1_1_100, 5'b1_0_000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 1'b0;
    logic nrz_in = 1'b0;
    logic fmt_nrz = 1'b0;
    logic half_width = 1'b0;
    logic viol_req = 1'b0;
    logic pos_rail, neg_rail, viol_done;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bipolar_line_encoder i_bipolar_line_encoder (
        .clk        (clk),
        .rst        (rst),
        .bit_stb    (bit_stb),
        .nrz_in     (nrz_in),
        .fmt_nrz    (fmt_nrz),
        .half_width (half_width),
        .viol_req   (viol_req),
        .pos_rail   (pos_rail),
        .neg_rail   (neg_rail),
        .viol_done  (viol_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual pos/neg/viol=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge that starts the next bit
    task automatic send_bit(input logic d, input logic r,
                            output logic [2:0] h1, output logic [2:0] h2);
        bit_stb  = 1'b1;
        nrz_in   = d;
        viol_req = r;
        @(negedge clk);
        h1 = {pos_rail, neg_rail, viol_done};
        bit_stb = 1'b0;
        @(negedge clk);
        h2 = {pos_rail, neg_rail, viol_done};
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bit_stb = 1'b0;
        viol_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 rails low in reset", {pos_rail, neg_rail, viol_done}, 3'b000);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] h1, h2;
        @(negedge clk);
        do_reset();

        // R1 R3 R4 R5 R6 R8: table walk, bipolar full width
        for (int i = 0; i < NVEC; i++) begin
            send_bit(VEC[i][3], VEC[i][4], h1, h2);
            check($sformatf("R1/R5/R6/R8 vec %0d first half", i), h1, VEC[i][2:0]);
            check($sformatf("R3 vec %0d second half full width", i), h2, VEC[i][2:0]);
        end

        // R3: half-width pulses
        half_width = 1'b1;
        do_reset();
        send_bit(1'b1, 1'b0, h1, h2);
        check("R3 half first +", h1, 3'b100);
        check("R3 half second idle", h2, 3'b000);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R3 half first -", h1, 3'b010);
        check("R3 half second idle", h2, 3'b000);
        send_bit(1'b0, 1'b0, h1, h2);
        check("R3 half zero", h1, 3'b000);
        half_width = 1'b0;

        // R2: NRZ format
        fmt_nrz = 1'b1;
        send_bit(1'b1, 1'b0, h1, h2);
        check("R2 nrz one", h1, 3'b100);
        check("R2 nrz one held", h2, 3'b100);
        send_bit(1'b0, 1'b0, h1, h2);
        check("R2 nrz zero", h1, 3'b000);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R2 nrz one again", h1, 3'b100);
        fmt_nrz = 1'b0;

        // R7: short request pulse still honoured, exactly once
        do_reset();
        send_bit(1'b1, 1'b1, h1, h2);
        check("R7 arm bit +", h1, 3'b100);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R7 count1 -", h1, 3'b010);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R7 count2 +", h1, 3'b100);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R7 count3 -", h1, 3'b010);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R7 violation repeats -", h1, 3'b011);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R7 after violation +", h1, 3'b100);
        send_bit(1'b1, 1'b0, h1, h2);
        check("R7 no second violation", h1, 3'b010);

        // R9: reset cancels an armed request and restores polarity
        do_reset();
        send_bit(1'b1, 1'b1, h1, h2);
        send_bit(1'b1, 1'b1, h1, h2);
        check("R9 pre-reset mark -", h1, 3'b010);
        do_reset();
        for (int k = 0; k < 6; k++) begin
            send_bit(1'b1, 1'b0, h1, h2);
            check($sformatf("R9 after reset bit %0d", k), h1,
                  (k % 2 == 0) ? 3'b100 : 3'b010);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule